// File: doc/BRIEF.md
# Time-Constant Bit-Rate Generator

This block produces the bit clock for one serial channel. A 16-bit time constant is written as two byte registers. A down-counter is clocked by one of two tick sources: the peripheral clock enable or an external clock enable. Each time the counter reaches zero it reloads and flips a square-wave output, so one output period lasts 2×(TC+2) source ticks. For a wanted rate, software computes TC = (f + bps) / (2·bps) − 2 with integer division. Every reload also gives a one-cycle zero-count pulse. That pulse can raise a status interrupt, and the counter's at-zero state can be read back.

A prescaler follows the generator. It counts rising edges of the square wave and emits a sampling tick once every 1, 16, 32 or 64 edges, as picked by a mode register. A mode write that asks for 1.5 stop bits together with the divide-by-1 setting is refused as a whole. Everything runs on one system clock: both tick sources and all register writes are single-cycle enables.

Top module: `tc_bitrate_gen`

## Requirements
- R1: While enabled, the output `brg_out` flips once every TC+2 ticks of the selected source, counting the tick that causes the flip. One full period is therefore 2×(TC+2) ticks, for every TC from 0 to 65535.
- R2: Control register (address 14) bit 1 picks the source. When it is set, `pclk_tick` drives the count; when it is clear, `ext_tick` drives it, and ticks on the other input have no effect.
- R3: Control register bit 0 enables the countdown. While it is clear, the count and `brg_out` hold their values, and counting resumes from the held count once the bit is set again.
- R4: The time constant is written as a low byte (address 12) and a high byte (address 13). A new value is picked up only at the next reload and never shortens or stretches the half period already in progress.
- R5: `zc_pulse` is high for exactly one cycle, in the cycle in which `brg_out` flips. Reading address 0 returns bit 1 set exactly while the counter holds zero, and all other bits zero.
- R6: `zc_irq` follows `zc_pulse` when bit 1 of the status-interrupt register (address 15) is set, and stays low otherwise.
- R7: Reading address 12 returns the low byte of the time constant, and reading address 13 returns the high byte.
- R8: Mode register (address 4) bits 7:6 set the prescale: 00 gives ÷1, 01 gives ÷16, 10 gives ÷32, 11 gives ÷64. `bit_tick` pulses for one cycle on every Nth rising edge of `brg_out`, in the same cycle as that edge.
- R9: A mode write with bits 7:6 = 00 and bits 3:2 = 10 (1.5 stop bits at ÷1) is discarded. The mode register and its readback keep their previous value.
- R10: After reset, `brg_out`, `zc_pulse`, `zc_irq` and `bit_tick` are low, the counter is at zero, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pclk_tick | input | 1 | Peripheral clock enable, one cycle per source tick |
| ext_tick | input | 1 | External clock enable, one cycle per source tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Combinational read data |
| brg_out | output | 1 | Square-wave bit clock |
| zc_pulse | output | 1 | One-cycle pulse on each terminal count |
| zc_irq | output | 1 | Zero-count status interrupt request |
| bit_tick | output | 1 | Prescaled sampling tick |

## Verification
The properties assume that each tick source and each write strobe is a single-cycle enable. They also assume that software never splits a time-constant update across a reload. The bench keeps within both: it drives the ticks and writes on the falling edge, one cycle wide, and it writes both bytes right after a flip, while the half period is still far from its end. Because a half period is never shorter than two ticks, the checks that zero-count pulses never arrive back to back, and that every flip coincides with a pulse, hold for any legal input.

// File: rtl/tcbg_pkg.sv
package tcbg_pkg;
  localparam int BYTE_W = 8;
  localparam int TC_W   = 2 * BYTE_W;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_STAT = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd4;
  localparam logic [ADDR_W-1:0] A_TCLO = 4'd12;
  localparam logic [ADDR_W-1:0] A_TCHI = 4'd13;
  localparam logic [ADDR_W-1:0] A_CTL  = 4'd14;
  localparam logic [ADDR_W-1:0] A_SIE  = 4'd15;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_SRC_BIT = 1;
  localparam int SIE_ZC_BIT  = 1;
  localparam int STAT_ZC_BIT = 1;

  localparam int MAX_DIV = 64;
  localparam int DCNT_W  = $clog2(MAX_DIV);

  typedef enum logic [1:0] {
    DIV1  = 2'b00,
    DIV16 = 2'b01,
    DIV32 = 2'b10,
    DIV64 = 2'b11
  } div_e;

  localparam logic [1:0] STOP_1P5 = 2'b10;
endpackage

// File: rtl/tcbg_regs.sv
module tcbg_regs
  import tcbg_pkg::*;
(
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              at_zero,
  output logic [BYTE_W-1:0] rd_data,
  output logic [TC_W-1:0]   tc_val,
  output logic              gen_en,
  output logic              src_pclk,
  output logic              zc_ie,
  output div_e              div_sel
);
  logic [TC_W-1:0]   tc_q,   tc_d;
  logic [BYTE_W-1:0] mode_q, mode_d;
  logic [BYTE_W-1:0] ctl_q,  ctl_d;
  logic [BYTE_W-1:0] sie_q,  sie_d;
  logic              mode_bad;

  assign mode_bad = (wr_data[7:6] == DIV1) && (wr_data[3:2] == STOP_1P5);

  always_comb begin
    tc_d   = tc_q;
    mode_d = mode_q;
    ctl_d  = ctl_q;
    sie_d  = sie_q;
    if (wr_en) begin
      case (wr_addr)
        A_TCLO: tc_d[BYTE_W-1:0]    = wr_data;
        A_TCHI: tc_d[TC_W-1:BYTE_W] = wr_data;
        A_MODE: if (!mode_bad) mode_d = wr_data;
        A_CTL:  ctl_d = wr_data;
        A_SIE:  sie_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tc_q   <= '0;
      mode_q <= '0;
      ctl_q  <= '0;
      sie_q  <= '0;
    end else begin
      tc_q   <= tc_d;
      mode_q <= mode_d;
      ctl_q  <= ctl_d;
      sie_q  <= sie_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STAT: rd_data[STAT_ZC_BIT] = at_zero;
      A_MODE: rd_data = mode_q;
      A_TCLO: rd_data = tc_q[BYTE_W-1:0];
      A_TCHI: rd_data = tc_q[TC_W-1:BYTE_W];
      A_CTL:  rd_data = ctl_q;
      A_SIE:  rd_data = sie_q;
      default: rd_data = '0;
    endcase
  end

  assign tc_val   = tc_q;
  assign gen_en   = ctl_q[CTL_EN_BIT];
  assign src_pclk = ctl_q[CTL_SRC_BIT];
  assign zc_ie    = sie_q[SIE_ZC_BIT];
  assign div_sel  = div_e'(mode_q[7:6]);
endmodule

// File: rtl/tcbg_counter.sv
module tcbg_counter
  import tcbg_pkg::*;
#(
  parameter int CNT_W = TC_W + 1
)(
  input  logic            clk,
  input  logic            srst_n,
  input  logic            pclk_tick,
  input  logic            ext_tick,
  input  logic            src_pclk,
  input  logic            gen_en,
  input  logic [TC_W-1:0] tc_val,
  output logic            brg_out,
  output logic            zc_pulse,
  output logic            at_zero,
  output logic            rise_ev
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             zc_q,  zc_d;
  logic             tick;
  logic             reload;

  assign tick    = src_pclk ? pclk_tick : ext_tick;
  assign at_zero = (cnt_q == '0);
  assign reload  = gen_en && tick && at_zero;
  assign rise_ev = reload && !out_q;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    zc_d  = 1'b0;
    if (gen_en && tick) begin
      if (at_zero) begin
        cnt_d = {1'b0, tc_val} + CNT_W'(1);
        out_d = ~out_q;
        zc_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      zc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
      zc_q  <= zc_d;
    end
  end

  assign brg_out  = out_q;
  assign zc_pulse = zc_q;
endmodule

// File: rtl/tcbg_prescale.sv
module tcbg_prescale
  import tcbg_pkg::*;
(
  input  logic clk,
  input  logic srst_n,
  input  logic rise_ev,
  input  div_e div_sel,
  output logic bit_tick
);
  logic [DCNT_W-1:0] dcnt_q, dcnt_d;
  logic [DCNT_W-1:0] lim;
  logic              tick_q, tick_d;

  always_comb begin
    case (div_sel)
      DIV1:    lim = DCNT_W'(0);
      DIV16:   lim = DCNT_W'(15);
      DIV32:   lim = DCNT_W'(31);
      default: lim = DCNT_W'(MAX_DIV - 1);
    endcase
  end

  always_comb begin
    dcnt_d = dcnt_q;
    tick_d = 1'b0;
    if (rise_ev) begin
      if (dcnt_q >= lim) begin
        dcnt_d = '0;
        tick_d = 1'b1;
      end else begin
        dcnt_d = dcnt_q + DCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dcnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_d;
      tick_q <= tick_d;
    end
  end

  assign bit_tick = tick_q;
endmodule

// File: rtl/tc_bitrate_gen.sv
module tc_bitrate_gen
  import tcbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_tick,
  input  logic              ext_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              brg_out,
  output logic              zc_pulse,
  output logic              zc_irq,
  output logic              bit_tick
);
  logic [1:0]      rst_sync;
  logic            srst_n;
  logic [TC_W-1:0] tc_val;
  logic            gen_en;
  logic            src_pclk;
  logic            zc_ie;
  div_e            div_sel;
  logic            at_zero;
  logic            rise_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  tcbg_regs u_regs (
    .clk      (clk),
    .srst_n   (srst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .at_zero  (at_zero),
    .rd_data  (rd_data),
    .tc_val   (tc_val),
    .gen_en   (gen_en),
    .src_pclk (src_pclk),
    .zc_ie    (zc_ie),
    .div_sel  (div_sel)
  );

  tcbg_counter u_cnt (
    .clk       (clk),
    .srst_n    (srst_n),
    .pclk_tick (pclk_tick),
    .ext_tick  (ext_tick),
    .src_pclk  (src_pclk),
    .gen_en    (gen_en),
    .tc_val    (tc_val),
    .brg_out   (brg_out),
    .zc_pulse  (zc_pulse),
    .at_zero   (at_zero),
    .rise_ev   (rise_ev)
  );

  tcbg_prescale u_pre (
    .clk      (clk),
    .srst_n   (srst_n),
    .rise_ev  (rise_ev),
    .div_sel  (div_sel),
    .bit_tick (bit_tick)
  );

  assign zc_irq = zc_pulse && zc_ie;
endmodule

// File: rtl/tcbg_chk.sv
module tcbg_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       zc_pulse,
  input logic       zc_irq,
  input logic       brg_out,
  input logic       bit_tick,
  input logic       gen_en,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [1:0] div_sel
);
  // R5
  zc_no_repeat_chk: assert property (@(posedge clk) disable iff (!srst_n)
    zc_pulse |=> !zc_pulse);

  // R1
  flip_with_zc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (brg_out != $past(brg_out)) == zc_pulse);

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !gen_en |=> $stable(brg_out) && !zc_pulse);

  // R6
  irq_needs_zc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    zc_irq |-> zc_pulse);

  // R8
  tick_on_rise_chk: assert property (@(posedge clk) disable iff (!srst_n)
    bit_tick |-> zc_pulse && brg_out);

  // R9
  bad_mode_kept_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && wr_addr == 4'd4 && wr_data[7:6] == 2'b00 && wr_data[3:2] == 2'b10)
      |=> $stable(div_sel));
endmodule

bind tc_bitrate_gen tcbg_chk u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .zc_pulse (zc_pulse),
  .zc_irq   (zc_irq),
  .brg_out  (brg_out),
  .bit_tick (bit_tick),
  .gen_en   (gen_en),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .div_sel  (div_sel)
);

// File: tb/test_tc_bitrate_gen.sv
module test_tc_bitrate_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pclk_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       brg_out, zc_pulse, zc_irq, bit_tick;

  int compared = 0;
  int mismatched = 0;
  int pclk_gap = 1;
  int ext_gap = 2;
  int phase = 0;

  logic en_m = 1'b0, src_m = 1'b0;
  logic cnt_tick = 1'b0;
  logic last_out = 1'b0;
  int ticks_since = 0, last_half = 0, toggles = 0;
  int zc_count = 0, irq_count = 0, flip_count = 0;
  int rises_since = 0, last_rises = 0, bticks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_bitrate_gen i_tc_bitrate_gen (
    .clk(clk), .rst_n(rst_n), .pclk_tick(pclk_tick), .ext_tick(ext_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .brg_out(brg_out),
    .zc_pulse(zc_pulse), .zc_irq(zc_irq), .bit_tick(bit_tick)
  );

  // tick generators, driven away from the active edge
  always @(negedge clk) begin
    phase <= phase + 1;
    pclk_tick <= (pclk_gap <= 1) ? 1'b1 : ((phase % pclk_gap) == 0);
    ext_tick  <= (ext_gap <= 1) ? 1'b1 : (((phase + 1) % ext_gap) == 0);
  end

  // model of which tick the design consumed at this edge
  always @(posedge clk) begin
    cnt_tick <= en_m && (src_m ? pclk_tick : ext_tick);
    if (wr_en && wr_addr == 4'd14) begin
      en_m  <= wr_data[0];
      src_m <= wr_data[1];
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cnt_tick) ticks_since++;
      if (zc_pulse) zc_count++;
      if (zc_irq) irq_count++;
      if (brg_out != last_out) begin
        last_half = ticks_since;
        ticks_since = 0;
        toggles++;
        flip_count++;
        if (brg_out) rises_since++;
      end
      if (bit_tick) begin
        last_rises = rises_since;
        rises_since = 0;
        bticks++;
      end
      last_out = brg_out;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wait_toggles(input int n);
    int t0 = toggles;
    while (toggles < t0 + n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_bticks(input int n);
    int b0 = bticks;
    while (bticks < b0 + n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_tc(input int tc);
    wr(4'd12, tc[7:0]);
    wr(4'd13, tc[15:8]);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int v;
    int z0, i0;
    logic b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 brg_out", brg_out, 0);
    chk("R10 zc_pulse", zc_pulse, 0);
    chk("R10 zc_irq", zc_irq, 0);
    chk("R10 bit_tick", bit_tick, 0);
    rd(4'd12, v); chk("R10 tc lo", v, 0);
    rd(4'd13, v); chk("R10 tc hi", v, 0);
    rd(4'd4, v);  chk("R10 mode", v, 0);
    rd(4'd0, v);  chk("R10 R5 status at zero", v, 8'h02);

    // R1 sweep with pclk every cycle, then every third cycle
    for (int g = 1; g <= 3; g += 2) begin
      pclk_gap = g;
      for (int tc = 0; tc < 10; tc++) begin
        wr(4'd14, 8'h02);
        set_tc(tc);
        wr(4'd14, 8'h03);
        wait_toggles(3);
        chk($sformatf("R1 half period tc=%0d gap=%0d", tc, g), last_half, tc + 2);
      end
    end
    pclk_gap = 1;
    wr(4'd14, 8'h02);
    set_tc(300);
    wr(4'd14, 8'h03);
    wait_toggles(3);
    chk("R1 half period tc=300", last_half, 302);

    // R7 readback
    rd(4'd12, v); chk("R7 tc lo", v, 300 % 256);
    rd(4'd13, v); chk("R7 tc hi", v, 300 / 256);

    // R2 external source, ticks every 2nd cycle vs pclk every cycle
    wr(4'd14, 8'h00);
    set_tc(5);
    ext_gap = 2;
    wr(4'd14, 8'h01);
    wait_toggles(3);
    chk("R2 ext source half period", last_half, 7);
    wr(4'd14, 8'h00);
    ext_gap = 3;
    wr(4'd14, 8'h01);
    wait_toggles(3);
    chk("R2 ext source gap3", last_half, 7);

    // R5 / R6 pulse accounting
    wr(4'd14, 8'h03);
    set_tc(2);
    wait_toggles(2);
    z0 = zc_count; i0 = irq_count; flip_count = 0;
    wait_toggles(8);
    chk("R5 one pulse per flip", zc_count - z0, flip_count);
    chk("R6 irq off", irq_count - i0, 0);
    wr(4'd15, 8'h02);
    wait_toggles(1);
    z0 = zc_count; i0 = irq_count;
    wait_toggles(8);
    chk("R6 irq on follows pulse", irq_count - i0, zc_count - z0);
    wr(4'd15, 8'h00);

    // R4 new TC only at next reload
    set_tc(20);
    wait_toggles(2);
    set_tc(3);
    wait_toggles(1);
    chk("R4 current half keeps old TC", last_half, 22);
    wait_toggles(1);
    chk("R4 next half uses new TC", last_half, 5);

    // R3 disable holds
    set_tc(40);
    wait_toggles(2);
    repeat (5) @(negedge clk);
    wr(4'd14, 8'h02);
    b0 = brg_out;
    z0 = toggles;
    repeat (60) @(negedge clk);
    chk("R3 output held", brg_out, b0);
    chk("R3 no flips while off", toggles - z0, 0);
    rd(4'd0, v); chk("R5 status mid count", v, 0);
    wr(4'd14, 8'h03);
    wait_toggles(1);
    chk("R3 resume from held count", last_half, 42);

    // R8 prescale
    set_tc(0);
    wr(4'd4, 8'h44);
    wait_bticks(2);
    chk("R8 div16", last_rises, 16);
    wr(4'd4, 8'h84);
    wait_bticks(2);
    chk("R8 div32", last_rises, 32);
    wr(4'd4, 8'hC4);
    wait_bticks(2);
    chk("R8 div64", last_rises, 64);
    wr(4'd4, 8'h44);
    wait_bticks(2);

    // R9 refused mode write
    wr(4'd4, 8'h08);
    rd(4'd4, v); chk("R9 mode kept", v, 8'h44);
    wait_bticks(2);
    chk("R9 still div16", last_rises, 16);
    wr(4'd4, 8'h04);
    wait_bticks(2);
    chk("R8 div1", last_rises, 1);

    summary();
  end
endmodule